// File: doc/BRIEF.md
# Fixed-Priority Interrupt Request Resolver

This block is the request, mask and in-service core of a classic eight-line interrupt controller. It tracks level-sensitive request lines in a pending register and, under a mask supplied by the programming logic, decides whether the processor should be interrupted. When the processor acknowledges, the block picks the winning line, returns a vector formed from a programmable base, and moves that line from pending into service.

Software ends a service period with an end-of-interrupt strobe. A specific strobe names the level to retire. A non-specific strobe retires whichever in-service level has the highest priority. Both the pending and the in-service registers are exported so that the programming interface can read them back.

The vector comes back as a one-cycle valid pulse in the cycle after the acknowledge. It has no ready input: the processor consumes the vector in that cycle, so it cannot apply back-pressure. Acknowledge, end-of-interrupt and the interrupt output are plain control pins.

Top module: `prio_resolver`

## Requirements
- R1: A rising request line sets its pending bit at the next clock edge. A low request line clears its pending bit at the next clock edge. A line that stays high does not set its bit again after the bit was cleared by an acknowledge.
- R2: `irq_o` is high exactly when some unmasked pending bit has an index lower than every set in-service bit. If nothing is in service, any unmasked pending bit qualifies.
- R3: Line 0 has the highest priority. On acknowledge, the winner is the lowest-numbered eligible pending line.
- R4: The cycle after `ack_i`, `vec_vld_o` is high for one cycle. In that cycle, `vec_o` equals `base_i` plus the winning index, modulo 2^VEC_W.
- R5: An acknowledge with an eligible winner clears that line's pending bit and sets its in-service bit.
- R6: An acknowledge with no eligible request returns `base_i` plus (LINES-1) as the spurious vector and leaves both the pending and in-service registers unchanged.
- R7: A specific end-of-interrupt (`eoi_spec_i`) clears only the in-service bit whose index is `eoi_level_i`.
- R8: A non-specific end-of-interrupt (`eoi_any_i`) clears the lowest-numbered set in-service bit and leaves the others alone.
- R9: After a granted acknowledge, `irq_o` is low in the following cycle unless another eligible request remains.
- R10: The mask only gates eligibility. Masked lines still set and hold their pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | LINES | Level-sensitive request lines |
| mask_i | input | LINES | 1 blocks the line from eligibility |
| base_i | input | VEC_W | Vector base added to the winning index |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| eoi_spec_i | input | 1 | Specific end-of-interrupt strobe |
| eoi_any_i | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_level_i | input | IDX_W | In-service index for the specific strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector returned for the last acknowledge |
| vec_vld_o | output | 1 | One-cycle valid for vec_o |
| irr_o | output | LINES | Pending request register |
| isr_o | output | LINES | In-service register |

## Verification
The bench builds the block with the default eight lines and an eight-bit vector. At that size, every one of the 256 request patterns can be swept against four mask patterns, with the winner and the vector computed arithmetically in the bench. The eight-line size also allows every pairing of an in-service level with a new request level, covering both blocked and preempting cases, and a fully nested in-service register that is retired in scrambled specific order and in non-specific order. The eight-bit vector allows base values near the top of the range, so that vector wraparound is exercised.

// File: rtl/prio_pkg.sv
package prio_pkg;
  parameter int unsigned PRIO_LINES_DEF = 8;
  parameter int unsigned PRIO_VEC_W_DEF = 8;

  typedef enum logic [1:0] {
    ACK_IDLE     = 2'd0,
    ACK_GRANT    = 2'd1,
    ACK_SPURIOUS = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/prio_first_set.sv
module prio_first_set #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_req_capture.sv
module prio_req_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] irr_q;
  logic [N-1:0] rise;

  assign rise  = req_i & ~req_q;
  assign irr_o = irr_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_q <= '0;
    end else begin
      req_q <= req_i;
      irr_q <= rise | (irr_q & req_i & ~take_i);
    end
  end

  // R1: a line that was low leaves no pending bit behind
  a_r1_low_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((irr_o & ~$past(req_i)) == '0));

  // R1: a line that was low and is now high is pending
  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((req_q & ~$past(req_q) & ~irr_o) == '0));
endmodule

// File: rtl/prio_service.sv
module prio_service #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic          eoi_spec_i,
  input  logic          eoi_any_i,
  input  logic [IW-1:0] eoi_level_i,
  output logic [N-1:0]  isr_o,
  output logic          top_found_o,
  output logic [IW-1:0] top_idx_o
);
  logic [N-1:0] isr_q;
  logic [N-1:0] clr_spec;
  logic [N-1:0] clr_any;
  logic [N-1:0] one;

  assign one   = N'(1);
  assign isr_o = isr_q;

  prio_first_set #(.N(N), .IW(IW)) u_top (
    .bits_i  (isr_q),
    .found_o (top_found_o),
    .idx_o   (top_idx_o)
  );

  assign clr_spec = eoi_spec_i ? (one << eoi_level_i) : '0;
  assign clr_any  = (eoi_any_i && top_found_o) ? (one << top_idx_o) : '0;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~(clr_spec | clr_any)) | set_i;
  end

  // R7: specific retire touches exactly the named level
  a_r7_spec_only: assert property (@(posedge clk) disable iff (!rst_ni)
    (eoi_spec_i && !eoi_any_i && set_i == '0) |=>
      (!isr_o[$past(eoi_level_i)] &&
       (((isr_o ^ $past(isr_o)) & ~(one << $past(eoi_level_i))) == '0)));

  // R8: non-specific retire removes exactly one bit, the lowest set one
  a_r8_any_one: assert property (@(posedge clk) disable iff (!rst_ni)
    (eoi_any_i && !eoi_spec_i && set_i == '0 && isr_o != '0) |=>
      ($countones(isr_o) + 1 == $countones($past(isr_o)) &&
       ((isr_o & ($past(isr_o) - 1'b1)) == isr_o)));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
#(
  parameter int unsigned LINES = PRIO_LINES_DEF,
  parameter int unsigned VEC_W = PRIO_VEC_W_DEF,
  parameter int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [VEC_W-1:0] base_i,
  input  logic             ack_i,
  input  logic             eoi_spec_i,
  input  logic             eoi_any_i,
  input  logic [IDX_W-1:0] eoi_level_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o
);
  localparam logic [VEC_W-1:0] SPUR_OFS = VEC_W'(LINES - 1);

  logic [LINES-1:0] pend;
  logic             pend_found;
  logic [IDX_W-1:0] pend_idx;
  logic             isr_found;
  logic [IDX_W-1:0] isr_idx;
  logic             eligible;
  logic [LINES-1:0] grant;
  ack_kind_e        ack_kind;
  logic [VEC_W-1:0] vec_q;
  logic             vld_q;

  prio_req_capture #(.N(LINES)) u_cap (
    .clk    (clk),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .take_i (grant),
    .irr_o  (irr_o)
  );

  assign pend = irr_o & ~mask_i;

  prio_first_set #(.N(LINES), .IW(IDX_W)) u_pick (
    .bits_i  (pend),
    .found_o (pend_found),
    .idx_o   (pend_idx)
  );

  prio_service #(.N(LINES), .IW(IDX_W)) u_svc (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .set_i       (grant),
    .eoi_spec_i  (eoi_spec_i),
    .eoi_any_i   (eoi_any_i),
    .eoi_level_i (eoi_level_i),
    .isr_o       (isr_o),
    .top_found_o (isr_found),
    .top_idx_o   (isr_idx)
  );

  assign eligible = pend_found && (!isr_found || (pend_idx < isr_idx));
  assign irq_o    = eligible;

  always_comb begin
    if (!ack_i)        ack_kind = ACK_IDLE;
    else if (eligible) ack_kind = ACK_GRANT;
    else               ack_kind = ACK_SPURIOUS;
  end

  assign grant = (ack_kind == ACK_GRANT) ? (LINES'(1) << pend_idx) : '0;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ack_i;
      case (ack_kind)
        ACK_GRANT:    vec_q <= base_i + VEC_W'(pend_idx);
        ACK_SPURIOUS: vec_q <= base_i + SPUR_OFS;
        default:      vec_q <= vec_q;
      endcase
    end
  end

  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;

  // R2: an interrupt implies some unmasked pending line
  a_r2_irq_has_source: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> ((irr_o & ~mask_i) != '0));

  // R4: valid is a one-cycle echo of the acknowledge
  a_r4_vld_follows_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (vec_vld_o == $past(ack_i)));

  // R5: a granted acknowledge grows the in-service set by one
  a_r5_grant_sets_isr: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && irq_o && !eoi_spec_i && !eoi_any_i) |=>
      ($countones(isr_o) == $countones($past(isr_o)) + 1));

  // R6: a spurious acknowledge keeps service state and returns the last slot
  a_r6_spurious: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi_spec_i && !eoi_any_i) |=>
      ($stable(isr_o) && vec_o == $past(base_i) + SPUR_OFS));
endmodule

// File: tb/sim_prio_resolver.sv
module sim_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] req, mask, base;
  logic       ack, eoi_s, eoi_n;
  logic [2:0] lvl;
  logic       irq, vld;
  logic [7:0] vec, irr, isr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prio_resolver u0 (
    .clk(clk), .rst_ni(rst_ni), .req_i(req), .mask_i(mask), .base_i(base),
    .ack_i(ack), .eoi_spec_i(eoi_s), .eoi_any_i(eoi_n), .eoi_level_i(lvl),
    .irq_o(irq), .vec_o(vec), .vec_vld_o(vld), .irr_o(irr), .isr_o(isr)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int first(input int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic clear_all();
    req = 8'h00; mask = 8'h00; tick();
    chk("R4 valid pulse ends", vld, 0);
    eoi_n = 1'b1; repeat (8) tick(); eoi_n = 1'b0;
  endtask

  task automatic nest(input logic [7:0] lines);
    for (int k = 7; k >= 0; k--) begin
      if (lines[k]) begin
        req = 8'(1 << k); tick();
        do_ack();
        chk("R3 nested vector", vec, (base + k) & 8'hFF);
      end
    end
    req = 8'h00; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req = 0; mask = 0; base = 8'h20;
    ack = 0; eoi_s = 0; eoi_n = 0; lvl = 0;
    repeat (3) tick();
    chk("R1 reset irr", irr, 0);
    chk("R5 reset isr", isr, 0);
    chk("R2 reset irq", irq, 0);
    chk("R4 reset valid", vld, 0);
    rst_ni = 1'b1; tick();

    // Sweep all request patterns against several masks
    for (int p = 0; p < 256; p++) begin
      for (int mi = 0; mi < 4; mi++) begin
        int m, w;
        m = (mi == 0) ? 0 : (mi == 1) ? 8'hFF : (mi == 2) ? 8'h55 : ((p ^ 8'hA3) & 8'hFF);
        base = 8'((p * 7 + mi * 61) & 8'hFF);
        req = 8'(p); mask = 8'(m); tick();
        chk("R1 pending follows rise", irr, p);
        chk("R10 mask keeps pending", irr, p);
        w = first(p & ~m);
        chk("R2 irq level", irq, (w < 8) ? 1 : 0);
        do_ack();
        chk("R4 valid after ack", vld, 1);
        if (w < 8) begin
          chk("R3 R4 winner vector", vec, (base + w) & 8'hFF);
          chk("R5 isr set", isr, 1 << w);
          chk("R5 irr cleared", irr, p & ~(1 << w));
          chk("R9 irq drops", irq, 0);
        end else begin
          chk("R6 spurious vector", vec, (base + 7) & 8'hFF);
          chk("R6 isr unchanged", isr, 0);
          chk("R6 irr unchanged", irr, p);
        end
        clear_all();
      end
    end

    // In-service blocking and preemption, every pair of levels
    base = 8'h40;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        req = 8'(1 << a); tick(); do_ack();
        chk("R5 first grant", isr, 1 << a);
        req = 8'((1 << a) | (1 << b)); tick();
        chk("R1 held line not re-set", irr, (a == b) ? 0 : (1 << b));
        chk("R2 blocked by service", irq, (b < a) ? 1 : 0);
        do_ack();
        if (b < a) begin
          chk("R3 preempt vector", vec, 8'h40 + b);
          chk("R5 nested isr", isr, (1 << a) | (1 << b));
        end else begin
          chk("R6 blocked spurious", vec, 8'h47);
          chk("R6 blocked isr", isr, 1 << a);
        end
        clear_all();
      end
    end

    // Specific retire in scrambled order
    base = 8'h08;
    nest(8'hFF);
    chk("R5 full nest", isr, 8'hFF);
    begin
      int exp_isr;
      exp_isr = 8'hFF;
      for (int i = 0; i < 8; i++) begin
        int l;
        l = (i * 5) % 8;
        lvl = 3'(l); eoi_s = 1'b1; tick(); eoi_s = 1'b0;
        exp_isr = exp_isr & ~(1 << l);
        chk("R7 specific retire", isr, exp_isr);
      end
    end

    // Non-specific retire, contiguous then sparse
    nest(8'hFF);
    for (int k = 0; k < 8; k++) begin
      eoi_n = 1'b1; tick(); eoi_n = 1'b0;
      chk("R8 lowest retired", isr, (8'hFF << (k + 1)) & 8'hFF);
    end
    nest(8'hA4);
    chk("R5 sparse nest", isr, 8'hA4);
    eoi_n = 1'b1; tick(); eoi_n = 1'b0;
    chk("R8 sparse first", isr, 8'hA0);
    eoi_n = 1'b1; tick(); eoi_n = 1'b0;
    chk("R8 sparse second", isr, 8'h80);
    clear_all();

    // Vector wraparound at the top of the range
    base = 8'hFC;
    req = 8'h40; tick(); do_ack();
    chk("R4 wrapped vector", vec, 8'h02);
    clear_all();
    do_ack();
    chk("R6 wrapped spurious", vec, 8'h03);
    clear_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule